// File: doc/BRIEF.md
# Expansion DMA Bus-Takeover Arbiter

This block decides, cycle by cycle, who drives an 8-bit system bus that is shared by a CPU, a video controller and an expansion DMA engine. The CPU sees two control inputs from the arbiter. The ready line stalls it, but only in read cycles. The address-enable line cuts its address, data and read/write lines off the bus at once, within the same cycle, with no register in the path.

The DMA engine is armed with a transfer length. It starts when the CPU writes to a fixed trigger address. From the next cycle it raises a single request line, and that one line pulls both CPU ready and CPU address-enable low. A CPU still in the middle of a read-modify-write therefore loses its final write: the value it modified never reaches memory. The dummy write that fired the trigger does reach memory.

The video controller warns of its takeover by pulling bus-available low. After three such cycles it owns the bus. The DMA engine holds its transfer strobes back whenever bus-available is low. The data path of the transfer and the video fetch logic lie outside this block.

Top module: `bus_takeover_arbiter`

## Requirements
- R1: After reset, cpu_rdy and cpu_aec are 1, bus_owner is 0 (CPU), and dma_req and dma_strobe are 0.
- R2: In any cycle in which vid_ba is 0, cpu_rdy is 0. A CPU write in one of the first three consecutive cycles with vid_ba at 0 still reaches memory (mem_we is 1).
- R3: In the fourth and later consecutive cycles with vid_ba at 0, cpu_aec is 0 and bus_owner is 1 (video), and CPU writes are blocked (mem_we is 0).
- R4: A one-cycle dma_arm pulse captures dma_len and arms the engine. A CPU write to address 0xFF00 while the engine is armed and the CPU is connected starts the transfer, and dma_req is 1 from the next cycle. The trigger write itself reaches memory.
- R5: While dma_req is 1, cpu_rdy and cpu_aec are both 0, bus_owner is 2 (DMA) unless the video controller owns the bus, and no CPU write reaches memory.
- R6: A read-modify-write increment of 0xFF00 while the engine is armed leaves memory holding the value from before the increment. The same increment on an ordinary address stores the incremented value.
- R7: dma_strobe is 1 only in cycles where dma_req and vid_ba are both 1. A transfer issues exactly dma_len+1 strobes, and the count is kept across pauses.
- R8: In the cycle after the last strobe, dma_req is 0, and with vid_ba at 1, cpu_rdy and cpu_aec are both 1.
- R9: A write to 0xFF00 while the engine is not armed is an ordinary memory write and does not raise dma_req.
- R10: A CPU read of 0xFF00 while the engine is armed does not start a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | The CPU performs a bus cycle |
| cpu_we | input | 1 | 1 for a CPU write cycle, 0 for a read cycle |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| vid_ba | input | 1 | Bus-available from the video controller, low ahead of its takeover |
| dma_arm | input | 1 | One-cycle pulse that arms the engine |
| dma_len | input | 8 | Transfer length minus one, captured on dma_arm |
| cpu_rdy | output | 1 | CPU ready (stalls read cycles when 0) |
| cpu_aec | output | 1 | CPU address-enable (disconnects the CPU when 0) |
| bus_owner | output | 2 | Bus owner: 0 CPU, 1 video, 2 DMA |
| dma_req | output | 1 | DMA request line driving both ready and address-enable |
| dma_strobe | output | 1 | One transfer beat of the DMA engine |
| mem_we | output | 1 | Write enable for a CPU write that reaches memory |
| mem_addr | output | 16 | Memory address during CPU ownership |
| mem_wdata | output | 8 | Memory write data |

## Verification
Every cycle, the assertions check the properties that hold at any single moment. A raised request always holds ready and address-enable low. A disconnected CPU never produces a memory write. A strobe never appears with bus-available low. A qualifying trigger write always raises the request one cycle later. Video ownership only appears after three earlier low cycles of bus-available.

Some behaviour takes several cycles and a memory model to show, so only the bench scenarios demonstrate it. One scenario checks that a read-modify-write on the trigger address leaves the old value in memory while the same instruction elsewhere stores the new one. The bench also counts strobes against the armed length across random pauses, and checks that the release comes exactly one cycle after the last beat.

// File: rtl/busarb_pkg.sv
package busarb_pkg;

    localparam int DEF_ADDR_W = 16;
    localparam int DEF_DATA_W = 8;
    localparam int DEF_LEN_W  = 8;
    localparam int DEF_LEAD   = 3;

    typedef enum logic [1:0] {
        OWN_CPU   = 2'd0,
        OWN_VIDEO = 2'd1,
        OWN_DMA   = 2'd2
    } owner_e;

    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_RUN  = 1'b1
    } eng_e;

    // Video beats DMA, DMA beats CPU.
    function automatic owner_e pick_owner(logic video_has, logic dma_has);
        if (video_has)
            return OWN_VIDEO;
        else if (dma_has)
            return OWN_DMA;
        return OWN_CPU;
    endfunction

endpackage

// File: rtl/ba_lead_tracker.sv
module ba_lead_tracker #(
    parameter int LEAD = busarb_pkg::DEF_LEAD
) (
    input  logic clk,
    input  logic rst,
    input  logic ba,
    output logic video_owns
);
    localparam int CW = $clog2(LEAD + 1);
    localparam logic [CW-1:0] LEAD_V = CW'(LEAD);

    logic [CW-1:0] low_cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            low_cnt_q <= '0;
        else if (ba)
            low_cnt_q <= '0;
        else if (low_cnt_q != LEAD_V)
            low_cnt_q <= low_cnt_q + 1'b1;
    end

    assign video_owns = !ba && (low_cnt_q == LEAD_V);
endmodule

// File: rtl/dma_sequencer.sv
module dma_sequencer #(
    parameter int ADDR_W = busarb_pkg::DEF_ADDR_W,
    parameter int LEN_W  = busarb_pkg::DEF_LEN_W,
    parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'hFF00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm,
    input  logic [LEN_W-1:0]  len,
    input  logic              cpu_valid,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_connected,
    input  logic              ba,
    output logic              dma_req,
    output logic              strobe,
    output logic              armed
);
    import busarb_pkg::*;

    eng_e             state_q;
    logic             armed_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] left_q;
    logic             trig;

    assign trig = cpu_valid && cpu_we && (cpu_addr == TRIG_ADDR)
                  && cpu_connected && armed_q && (state_q == ENG_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ENG_IDLE;
            armed_q <= 1'b0;
            len_q   <= '0;
            left_q  <= '0;
        end else begin
            case (state_q)
                ENG_IDLE: begin
                    if (trig) begin
                        state_q <= ENG_RUN;
                        left_q  <= len_q;
                        armed_q <= 1'b0;
                    end else if (arm) begin
                        armed_q <= 1'b1;
                        len_q   <= len;
                    end
                end
                ENG_RUN: begin
                    if (ba) begin
                        if (left_q == '0)
                            state_q <= ENG_IDLE;
                        else
                            left_q <= left_q - 1'b1;
                    end
                end
                default: state_q <= ENG_IDLE;
            endcase
        end
    end

    assign dma_req = (state_q == ENG_RUN);
    assign strobe  = dma_req && ba;
    assign armed   = armed_q;
endmodule

// File: rtl/bus_gate.sv
module bus_gate (
    input  logic       dma_req,
    input  logic       video_owns,
    input  logic       ba,
    input  logic       cpu_valid,
    input  logic       cpu_we,
    output logic       cpu_rdy,
    output logic       cpu_aec,
    output logic [1:0] owner,
    output logic       mem_we
);
    import busarb_pkg::*;

    owner_e own;

    always_comb begin
        own     = pick_owner(video_owns, dma_req);
        cpu_rdy = ba && !dma_req;
        cpu_aec = (own == OWN_CPU);
        mem_we  = cpu_valid && cpu_we && cpu_aec;
    end

    assign owner = own;
endmodule

// File: rtl/bus_takeover_arbiter.sv
module bus_takeover_arbiter #(
    parameter int ADDR_W = busarb_pkg::DEF_ADDR_W,
    parameter int DATA_W = busarb_pkg::DEF_DATA_W,
    parameter int LEN_W  = busarb_pkg::DEF_LEN_W,
    parameter int LEAD   = busarb_pkg::DEF_LEAD,
    parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'hFF00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              vid_ba,
    input  logic              dma_arm,
    input  logic [LEN_W-1:0]  dma_len,
    output logic              cpu_rdy,
    output logic              cpu_aec,
    output logic [1:0]        bus_owner,
    output logic              dma_req,
    output logic              dma_strobe,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    logic video_owns;
    logic armed;

    ba_lead_tracker #(.LEAD(LEAD)) i_lead (
        .clk(clk), .rst(rst), .ba(vid_ba), .video_owns(video_owns)
    );

    dma_sequencer #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .TRIG_ADDR(TRIG_ADDR)) i_seq (
        .clk(clk), .rst(rst), .arm(dma_arm), .len(dma_len),
        .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_connected(cpu_aec), .ba(vid_ba),
        .dma_req(dma_req), .strobe(dma_strobe), .armed(armed)
    );

    bus_gate i_gate (
        .dma_req(dma_req), .video_owns(video_owns), .ba(vid_ba),
        .cpu_valid(cpu_valid), .cpu_we(cpu_we),
        .cpu_rdy(cpu_rdy), .cpu_aec(cpu_aec), .owner(bus_owner), .mem_we(mem_we)
    );

    assign mem_addr  = cpu_addr;
    assign mem_wdata = cpu_wdata;
endmodule

// File: rtl/bus_takeover_checker.sv
module bus_takeover_checker #(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'hFF00
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_valid,
    input logic              cpu_we,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              vid_ba,
    input logic              cpu_rdy,
    input logic              cpu_aec,
    input logic [1:0]        bus_owner,
    input logic              dma_req,
    input logic              dma_strobe,
    input logic              mem_we,
    input logic              armed
);
    p_req_isolates_r5: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> (!cpu_rdy && !cpu_aec));

    p_no_write_detached_r5: assert property (@(posedge clk) disable iff (rst)
        !cpu_aec |-> !mem_we);

    p_ba_low_stalls_r2: assert property (@(posedge clk) disable iff (rst)
        !vid_ba |-> !cpu_rdy);

    p_strobe_gated_r7: assert property (@(posedge clk) disable iff (rst)
        dma_strobe |-> (vid_ba && dma_req));

    p_trigger_starts_r4: assert property (@(posedge clk) disable iff (rst)
        (cpu_valid && cpu_we && cpu_addr == TRIG_ADDR && cpu_aec && armed && !dma_req)
        |=> dma_req);

    p_video_after_lead_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_owner == 2'd1) |-> (!vid_ba && $past(!vid_ba, 1) && $past(!vid_ba, 2)
                                 && $past(!vid_ba, 3)));

    p_release_restores_r8: assert property (@(posedge clk) disable iff (rst)
        ($fell(dma_req) && vid_ba) |-> (cpu_rdy && cpu_aec));

    p_owner_code_r1: assert property (@(posedge clk) disable iff (rst)
        bus_owner != 2'd3);
endmodule

bind bus_takeover_arbiter bus_takeover_checker #(.ADDR_W(ADDR_W), .TRIG_ADDR(TRIG_ADDR)) i_chk (
    .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .vid_ba(vid_ba), .cpu_rdy(cpu_rdy), .cpu_aec(cpu_aec), .bus_owner(bus_owner),
    .dma_req(dma_req), .dma_strobe(dma_strobe), .mem_we(mem_we), .armed(armed)
);

// File: tb/test_bus_takeover_arbiter.sv
module test_bus_takeover_arbiter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_valid = 1'b0, cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        vid_ba = 1'b1, dma_arm = 1'b0;
    logic [7:0]  dma_len = '0;
    logic        cpu_rdy, cpu_aec, dma_req, dma_strobe, mem_we;
    logic [1:0]  bus_owner;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;

    always #5 clk = ~clk;

    bus_takeover_arbiter i_bus_takeover_arbiter (
        .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .vid_ba(vid_ba), .dma_arm(dma_arm), .dma_len(dma_len),
        .cpu_rdy(cpu_rdy), .cpu_aec(cpu_aec), .bus_owner(bus_owner), .dma_req(dma_req),
        .dma_strobe(dma_strobe), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    int errors = 0, checks = 0;
    int n_strobe = 0, bad_strobe = 0;
    logic s_rdy, s_aec, s_req, s_strobe, s_we;
    logic [1:0] s_owner;
    logic [7:0] mem [logic [15:0]];
    bit finished = 0;

    function automatic logic [7:0] mem_rd(logic [15:0] a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Sample just before the rising edge, update the memory model, move to the next falling edge.
    task automatic tick();
        #4;
        s_rdy = cpu_rdy; s_aec = cpu_aec; s_req = dma_req;
        s_strobe = dma_strobe; s_owner = bus_owner; s_we = mem_we;
        if (dma_strobe) n_strobe++;
        if (dma_strobe && !vid_ba) bad_strobe++;
        if (mem_we) mem[mem_addr] = mem_wdata;
        @(negedge clk);
    endtask

    task automatic cpu_wr(logic [15:0] a, logic [7:0] d);
        cpu_valid = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d;
        tick();
        cpu_valid = 0; cpu_we = 0;
    endtask

    task automatic cpu_rd(logic [15:0] a, output logic [7:0] d);
        cpu_valid = 1; cpu_we = 0; cpu_addr = a;
        for (int i = 0; i < 500; i++) begin
            tick();
            if (s_rdy) break;
        end
        d = mem_rd(a);
        cpu_valid = 0;
    endtask

    task automatic rmw_inc(logic [15:0] a);
        logic [7:0] v, dummy;
        cpu_rd(a, v);
        cpu_wr(a, v);
        cpu_wr(a, v + 8'd1);
        cpu_rd(16'h0200, dummy);
    endtask

    task automatic arm(logic [7:0] l);
        dma_arm = 1; dma_len = l;
        tick();
        dma_arm = 0;
    endtask

    initial begin
        logic [7:0] d;
        void'($urandom(32'd20240));
        repeat (3) @(negedge clk);
        rst = 0;
        tick();
        chk("R1", "rdy", s_rdy, 1); chk("R1", "aec", s_aec, 1);
        chk("R1", "owner", s_owner, 0); chk("R1", "req", s_req, 0);
        chk("R1", "strobe", s_strobe, 0);

        // R2 / R3: video lead-in
        vid_ba = 0;
        cpu_wr(16'h0010, 8'hA5);
        chk("R2", "rdy low", s_rdy, 0); chk("R2", "write passes", s_we, 1);
        tick(); chk("R2", "aec lead1", s_aec, 1);
        tick(); chk("R2", "aec lead2", s_aec, 1);
        cpu_wr(16'h0011, 8'h5A);
        chk("R3", "aec", s_aec, 0); chk("R3", "owner", s_owner, 1);
        chk("R3", "we blocked", s_we, 0);
        vid_ba = 1; tick();
        chk("R3", "owner back", s_owner, 0);
        chk("R2", "mem 0010", mem_rd(16'h0010), 8'hA5);
        chk("R3", "mem 0011", mem_rd(16'h0011), 8'h00);

        // R9: trigger address while unarmed
        cpu_wr(16'hFF00, 8'h11); tick();
        chk("R9", "no req", s_req, 0);
        chk("R9", "mem ff00", mem_rd(16'hFF00), 8'h11);

        // R10 then R4/R5/R7/R8
        arm(8'd2);
        cpu_rd(16'hFF00, d); tick();
        chk("R10", "read no req", s_req, 0);
        n_strobe = 0;
        cpu_wr(16'hFF00, 8'h33);
        chk("R4", "req before edge", s_req, 0);
        cpu_wr(16'h0020, 8'h99);
        chk("R4", "req next cycle", s_req, 1);
        chk("R5", "rdy", s_rdy, 0); chk("R5", "aec", s_aec, 0);
        chk("R5", "owner", s_owner, 2); chk("R5", "we", s_we, 0);
        tick(); tick();
        chk("R7", "last beat", s_strobe, 1);
        tick();
        chk("R8", "req off", s_req, 0); chk("R8", "aec", s_aec, 1); chk("R8", "rdy", s_rdy, 1);
        chk("R7", "strobes", n_strobe, 3);
        chk("R5", "mem 0020", mem_rd(16'h0020), 8'h00);
        chk("R4", "trigger stored", mem_rd(16'hFF00), 8'h33);

        // R7: pause keeps count
        arm(8'd1); n_strobe = 0;
        cpu_wr(16'hFF00, 8'h44);
        vid_ba = 0; tick(); tick();
        chk("R7", "paused strobes", n_strobe, 0); chk("R7", "held req", s_req, 1);
        vid_ba = 1; tick(); tick(); tick();
        chk("R7", "strobes after pause", n_strobe, 2); chk("R8", "released", s_req, 0);

        // R6: read-modify-write
        cpu_wr(16'h0030, 8'h41);
        rmw_inc(16'h0030);
        chk("R6", "ordinary inc", mem_rd(16'h0030), 8'h42);
        cpu_wr(16'hFF00, 8'h7F);
        arm(8'd1); n_strobe = 0;
        rmw_inc(16'hFF00);
        chk("R6", "trigger keeps old", mem_rd(16'hFF00), 8'h7F);
        chk("R6", "transfer ran", n_strobe, 2);

        // Random lengths and bus-available patterns
        for (int it = 0; it < 40; it++) begin
            logic [7:0] l;
            int lim;
            l = 8'($urandom_range(0, 7));
            vid_ba = 1; tick();
            arm(l); n_strobe = 0; bad_strobe = 0;
            cpu_wr(16'hFF00, 8'($urandom));
            lim = 0;
            do begin
                vid_ba = ($urandom_range(0, 9) < 7);
                tick(); lim++;
            end while (s_req && lim < 300);
            vid_ba = 1;
            chk("R7", "random strobe count", n_strobe, int'(l) + 1);
            chk("R7", "random no strobe while ba low", bad_strobe, 0);
        end

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule